// File: doc/BRIEF.md
# Dual-Mode Iterative Booth Multiply-Accumulate Unit

This unit is a multi-cycle multiply-accumulate engine for a small 32-bit RISC core. A single mode input picks one of two functions. In scalar mode it multiplies two signed 32-bit operands and adds a 32-bit accumulator. In packed mode each operand holds two signed 16-bit lanes: lane 0 in bits [15:0] and lane 1 in bits [31:16]. Both lane products are added to the accumulator. In both modes the result is truncated to 32 bits.

One radix-4 Booth datapath is shared by both modes. Each cycle it consumes one 8-bit slice of the multiplier operand, which gives four Booth digits and four partial-product rows, and adds the weighted rows into a 66-bit running partial. In scalar mode the four slices are used one after another, so the multiply takes four cycles. In packed mode the two lanes use two row groups side by side. A per-slice enable vector selects slices 0 and 2 together in the first cycle and slices 1 and 3 together in the second cycle, so the multiply takes two cycles. The Booth window at the lane boundary is cut so that lane 1 never sees lane 0's top bit. The accumulator is added once, on the last multiply edge.

The controller is a two-state machine. `S_IDLE` waits for work. `S_RUN` steps through the slices.
- Transition `T_LAUNCH` (`S_IDLE` to `S_RUN`) is taken when start is high in idle; the operands, accumulator and mode are captured.
- Transition `T_STEP` (`S_RUN` to `S_RUN`) is taken on every multiply edge except the last.
- Transition `T_FINISH` (`S_RUN` to `S_IDLE`) is taken on the last multiply edge; it writes the result and raises done for one cycle.

Top module: `dual_mode_booth_mac`

## Requirements
- R1: With `simd_i`=0 at launch, the result equals (acc + a*b) mod 2^32, with a and b read as signed 32-bit values.
- R2: With `simd_i`=1 at launch, the result equals (acc + a[15:0]*b[15:0] + a[31:16]*b[31:16]) mod 2^32, with every 16-bit field read as signed.
- R3: In packed mode `done_o` is high in the cycle after the second rising edge that follows the edge sampling start, and exactly two slices are enabled in every run cycle.
- R4: In scalar mode `done_o` is high in the cycle after the fourth rising edge that follows the edge sampling start, and exactly one slice is enabled in every run cycle.
- R5: `busy_o` is high from the edge after launch until the finishing edge. A start pulse while busy is ignored: the operands, accumulator and mode in flight are unchanged, and no extra done pulse follows.
- R6: `done_o` is a single-cycle pulse. `result_o` changes only on the edge that raises `done_o` and holds its value otherwise.
- R7: In packed mode the lanes are isolated: lane 1's Booth recoding starts from a zero bit below b[16], whatever the value of b[15].
- R8: After reset, `busy_o`=0, `done_o`=0 and `result_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch request, sampled only in idle |
| simd_i | input | 1 | Mode select: 1 = packed dual 16-bit, 0 = scalar 32-bit |
| op_a_i | input | 32 | Multiplicand (two 16-bit lanes in packed mode) |
| op_b_i | input | 32 | Multiplier (two 16-bit lanes in packed mode) |
| acc_i | input | 32 | Accumulator addend |
| busy_o | output | 1 | A multiply is in flight |
| done_o | output | 1 | One-cycle completion strobe |
| result_o | output | 32 | Truncated multiply-accumulate result, held between runs |

## Verification
The hardest situation to reach from the ports is a lane-boundary window error. A wrong Booth window only shows up when b[15] is set and lane 1 carries a non-zero multiplicand. Random operands rarely isolate that case. The stimulus therefore sweeps every pairing of the 16-bit values 0, 1, -1, 0x7FFF, 0x8000 and 0x1234 across the lanes, and adds targeted runs where lane 0's multiplier is 0x8000. A second run is started one cycle into a busy interval with the other mode and other operands, to show that nothing in flight is disturbed.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } mac_state_e;

    // Radix-4 Booth digit from a 3-bit window {hi, mid, lo}
    function automatic logic signed [2:0] booth_digit(input logic [2:0] w);
        logic signed [2:0] d;
        unique case (w)
            3'b000, 3'b111: d = 3'sd0;
            3'b001, 3'b010: d = 3'sd1;
            3'b011:         d = 3'sd2;
            3'b100:         d = -3'sd2;
            default:        d = -3'sd1;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/mac_sequencer.sv
`timescale 1ns/1ps
module mac_sequencer #(
    parameter int NSLICE = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              simd_i,
    output logic              busy_o,
    output logic              launch_o,
    output logic              finish_o,
    output logic              simd_q_o,
    output logic [NSLICE-1:0] slice_en_o
);
    import mac_pkg::*;

    localparam int IDX_W = (NSLICE > 1) ? $clog2(NSLICE) : 1;
    localparam int HALF  = NSLICE / 2;

    mac_state_e       state_q, state_d;
    logic [IDX_W-1:0] step_q, step_d;
    logic             simd_q, simd_d;
    logic [IDX_W-1:0] last_step;

    assign last_step = simd_q ? IDX_W'(HALF - 1) : IDX_W'(NSLICE - 1);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        step_d  = step_q;
        simd_d  = simd_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin            // T_LAUNCH
                    state_d = S_RUN;
                    step_d  = '0;
                    simd_d  = simd_i;
                end
            end
            S_RUN: begin
                if (step_q == last_step) begin // T_FINISH
                    state_d = S_IDLE;
                    step_d  = '0;
                end else begin                 // T_STEP
                    step_d  = step_q + 1'b1;
                end
            end
            default: state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            step_q  <= '0;
            simd_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            step_q  <= step_d;
            simd_q  <= simd_d;
        end
    end

    // Outputs
    always_comb begin
        busy_o     = 1'b0;
        launch_o   = 1'b0;
        finish_o   = 1'b0;
        slice_en_o = '0;
        unique case (state_q)
            S_IDLE: launch_o = start_i;
            S_RUN: begin
                busy_o   = 1'b1;
                finish_o = (step_q == last_step);
                slice_en_o[step_q] = 1'b1;
                if (simd_q)
                    slice_en_o[step_q + IDX_W'(HALF)] = 1'b1;
            end
            default: ;
        endcase
    end

    assign simd_q_o = simd_q;

endmodule

// File: rtl/mac_booth_encoder.sv
`timescale 1ns/1ps
module mac_booth_encoder #(
    parameter int DATA_W  = 32,
    parameter int SLICE_W = 8
) (
    input  logic [DATA_W-1:0]                 b_i,
    input  logic [DATA_W/SLICE_W-1:0]         slice_en_i,
    input  logic                              simd_i,
    output logic [SLICE_W:0]                  win0_o,
    output logic [SLICE_W:0]                  win1_o,
    output logic [$clog2(DATA_W)-1:0]         shamt_o
);
    localparam int NSLICE = DATA_W / SLICE_W;
    localparam int HALF   = NSLICE / 2;
    localparam int SH_W   = $clog2(DATA_W);

    logic [DATA_W:0] bx;
    int              lo_idx;
    int              hi_idx;

    assign bx = {b_i, 1'b0};

    always_comb begin
        lo_idx = 0;
        hi_idx = 0;
        for (int k = NSLICE - 1; k >= 0; k--)
            if (slice_en_i[k]) lo_idx = k;
        for (int k = 0; k < NSLICE; k++)
            if (slice_en_i[k]) hi_idx = k;
    end

    always_comb begin
        win0_o  = bx[lo_idx*SLICE_W +: SLICE_W+1];
        win1_o  = '0;
        shamt_o = SH_W'(lo_idx * SLICE_W);
        if (simd_i) begin
            win1_o = bx[hi_idx*SLICE_W +: SLICE_W+1];
            // cut the window at the lane boundary: lane 1 starts from zero
            if (hi_idx == HALF)
                win1_o[0] = 1'b0;
        end
    end

endmodule

// File: rtl/mac_booth_rows.sv
`timescale 1ns/1ps
module mac_booth_rows #(
    parameter int ACC_W   = 66,
    parameter int SLICE_W = 8
) (
    input  logic [SLICE_W:0]       win_i,
    input  logic [ACC_W-1:0]       mcand_i,
    output logic [ACC_W-1:0]       sum_o
);
    import mac_pkg::*;

    localparam int DIGITS = SLICE_W / 2;

    logic [ACC_W-1:0] row [DIGITS];

    for (genvar j = 0; j < DIGITS; j++) begin : g_row
        logic signed [2:0] dig;
        logic [ACC_W-1:0]  mag;
        assign dig = booth_digit(win_i[2*j +: 3]);
        always_comb begin
            unique case (dig)
                3'sd1:   mag = mcand_i;
                3'sd2:   mag = mcand_i << 1;
                -3'sd1:  mag = -mcand_i;
                -3'sd2:  mag = -(mcand_i << 1);
                default: mag = '0;
            endcase
        end
        assign row[j] = mag << (2 * j);
    end

    always_comb begin
        sum_o = '0;
        for (int j = 0; j < DIGITS; j++)
            sum_o = sum_o + row[j];
    end

endmodule

// File: rtl/dual_mode_booth_mac.sv
`timescale 1ns/1ps
module dual_mode_booth_mac #(
    parameter int DATA_W  = 32,
    parameter int SLICE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              simd_i,
    input  logic [DATA_W-1:0] op_a_i,
    input  logic [DATA_W-1:0] op_b_i,
    input  logic [DATA_W-1:0] acc_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] result_o
);
    localparam int NSLICE = DATA_W / SLICE_W;
    localparam int LANE_W = DATA_W / 2;
    localparam int ACC_W  = 2 * DATA_W + 2;
    localparam int SH_W   = $clog2(DATA_W);

    logic              launch, finish, simd_q;
    logic [NSLICE-1:0] slice_en;
    logic [DATA_W-1:0] a_q, b_q, acc_q, result_q;
    logic [ACC_W-1:0]  part_q, part_next;
    logic [ACC_W-1:0]  mcand0, mcand1, sum0, sum1;
    logic [SLICE_W:0]  win0, win1;
    logic [SH_W-1:0]   shamt;
    logic              done_q;

    mac_sequencer #(.NSLICE(NSLICE)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .simd_i     (simd_i),
        .busy_o     (busy_o),
        .launch_o   (launch),
        .finish_o   (finish),
        .simd_q_o   (simd_q),
        .slice_en_o (slice_en)
    );

    mac_booth_encoder #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_enc (
        .b_i        (b_q),
        .slice_en_i (slice_en),
        .simd_i     (simd_q),
        .win0_o     (win0),
        .win1_o     (win1),
        .shamt_o    (shamt)
    );

    // Multiplicand per row group: full word or sign-extended lane
    assign mcand0 = simd_q ? {{(ACC_W-LANE_W){a_q[LANE_W-1]}}, a_q[LANE_W-1:0]}
                           : {{(ACC_W-DATA_W){a_q[DATA_W-1]}}, a_q};
    assign mcand1 = {{(ACC_W-LANE_W){a_q[DATA_W-1]}}, a_q[DATA_W-1:LANE_W]};

    mac_booth_rows #(.ACC_W(ACC_W), .SLICE_W(SLICE_W)) u_rows0 (
        .win_i   (win0),
        .mcand_i (mcand0),
        .sum_o   (sum0)
    );

    mac_booth_rows #(.ACC_W(ACC_W), .SLICE_W(SLICE_W)) u_rows1 (
        .win_i   (win1),
        .mcand_i (mcand1),
        .sum_o   (sum1)
    );

    assign part_next = part_q + ((sum0 + sum1) << shamt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q      <= '0;
            b_q      <= '0;
            acc_q    <= '0;
            part_q   <= '0;
            result_q <= '0;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (launch) begin
                a_q    <= op_a_i;
                b_q    <= op_b_i;
                acc_q  <= acc_i;
                part_q <= '0;
            end else if (busy_o) begin
                part_q <= part_next;
                if (finish) begin
                    result_q <= acc_q + part_next[DATA_W-1:0];
                    done_q   <= 1'b1;
                end
            end
        end
    end

    assign done_o   = done_q;
    assign result_o = result_q;

endmodule

// File: rtl/mac_checker.sv
`timescale 1ns/1ps
module mac_checker #(
    parameter int DATA_W = 32,
    parameter int NSLICE = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              busy_o,
    input logic              done_o,
    input logic [DATA_W-1:0] result_o,
    input logic              simd_q,
    input logic [NSLICE-1:0] slice_en
);
    logic [3:0] cnt;
    logic       mode_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt       <= '0;
            mode_seen <= 1'b0;
        end else if (start_i && !busy_o) begin
            cnt <= '0;
        end else if (busy_o) begin
            cnt       <= cnt + 1'b1;
            mode_seen <= simd_q;
        end
    end

    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && mode_seen) |-> (cnt == 4'd2));

    p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !mode_seen) |-> (cnt == 4'd4));

    p_pair_slices_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && simd_q) |-> ($countones(slice_en) == 2));

    p_single_slice_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !simd_q) |-> ($countones(slice_en) == 1));

    p_mode_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> $stable(simd_q));

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_result_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable(result_o));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (slice_en == '0));

endmodule

bind dual_mode_booth_mac mac_checker #(.DATA_W(DATA_W), .NSLICE(NSLICE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .result_o (result_o),
    .simd_q   (simd_q),
    .slice_en (slice_en)
);

// File: tb/tb_dual_mode_booth_mac.sv
`timescale 1ns/1ps
module tb_dual_mode_booth_mac;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        simd = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, acc = '0;
    logic        busy, done;
    logic [31:0] result;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;   // 250 MHz

    dual_mode_booth_mac dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start),
        .simd_i   (simd),
        .op_a_i   (op_a),
        .op_b_i   (op_b),
        .acc_i    (acc),
        .busy_o   (busy),
        .done_o   (done),
        .result_o (result)
    );

    function automatic logic [31:0] model(input logic md, input logic [31:0] a,
                                          input logic [31:0] b, input logic [31:0] c);
        longint s;
        if (md)
            s = longint'($signed(a[15:0])) * longint'($signed(b[15:0]))
              + longint'($signed(a[31:16])) * longint'($signed(b[31:16]))
              + longint'($signed(c));
        else
            s = longint'($signed(a)) * longint'($signed(b)) + longint'($signed(c));
        return s[31:0];
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    // One operation; poke=1 fires a disturbing start one cycle into the run
    task automatic run_op(input logic md, input logic [31:0] a, input logic [31:0] b,
                          input logic [31:0] c, input bit poke, input string tag);
        logic [31:0] exp;
        int          cyc;
        int          lat;
        logic [31:0] held;
        exp = model(md, a, b, c);
        lat = md ? 2 : 4;
        @(negedge clk);
        start = 1'b1; simd = md; op_a = a; op_b = b; acc = c;
        @(negedge clk);                 // launch edge passed
        start = 1'b0;
        cyc = 0;
        check(busy == 1'b1, "R5 busy after launch", 32'(busy), 32'd1);
        if (poke) begin
            start = 1'b1; simd = ~md; op_a = ~a; op_b = b ^ 32'h5A5A_A5A5; acc = c + 32'd77;
        end
        while (!done && cyc < 10) begin
            @(negedge clk);
            start = 1'b0;
            cyc++;
        end
        check(cyc == lat, md ? "R3 packed latency" : "R4 scalar latency",
              32'(cyc), 32'(lat));
        check(result == exp, tag, result, exp);
        held = result;
        @(negedge clk);
        check(done == 1'b0, "R6 done single pulse", 32'(done), 32'd0);
        check(result == held, "R6 result held", result, held);
        if (poke) begin
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                check(done == 1'b0 && busy == 1'b0, "R5 no extra run from busy start",
                      {30'd0, busy, done}, 32'd0);
            end
        end
    endtask

    logic [15:0] lanes [6] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h1234};
    logic [31:0] words [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                               32'h8000_0000, 32'h0000_8000, 32'h1234_5678, 32'hFFFF_0000};

    task automatic main_flow();
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R8 reset busy", 32'(busy), 32'd0);
        check(done == 1'b0, "R8 reset done", 32'(done), 32'd0);
        check(result == 32'd0, "R8 reset result", result, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Lane corner cases
        run_op(1'b1, 32'h8000_8000, 32'h8000_8000, 32'd0, 1'b0, "R2 0x8000 squared per lane");
        run_op(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd5, 1'b0, "R2 all ones");
        run_op(1'b1, 32'h0000_1234, 32'h7FFF_0000, 32'd9, 1'b0, "R2 zero lanes");
        run_op(1'b1, 32'h0001_0000, 32'h0001_8000, 32'd0, 1'b0, "R7 lane boundary b15 set");
        run_op(1'b1, 32'h7FFF_0003, 32'h0003_8000, 32'd0, 1'b0, "R7 lane boundary mixed");
        run_op(1'b0, 32'h8000_0000, 32'h8000_0000, 32'd1, 1'b0, "R1 min times min");
        run_op(1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, "R1 all ones");

        // Busy-start rejection in both modes
        run_op(1'b0, 32'h1234_5678, 32'h9ABC_DEF0, 32'h0000_0042, 1'b1, "R5 scalar kept through poke");
        run_op(1'b1, 32'h1234_8765, 32'h8001_7FFF, 32'h0000_1000, 1'b1, "R5 packed kept through poke");

        // Packed sweep over lane value pairs
        for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
                for (int k = 0; k < 6; k++)
                    run_op(1'b1, {lanes[i], lanes[j]}, {lanes[(i + k) % 6], lanes[k]},
                           32'(i * 7 + k), 1'b0, "R2 packed sweep");

        // Scalar sweep over word pairs
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                run_op(1'b0, words[i], words[j], words[(i + j) % 8], 1'b0, "R1 scalar sweep");

        // Random operands, both modes
        for (int n = 0; n < 150; n++) begin
            run_op(1'b0, $urandom, $urandom, $urandom, 1'b0, "R1 scalar random");
            run_op(1'b1, $urandom, $urandom, $urandom, 1'b0, "R2 packed random");
        end
    endtask

    initial begin
        fork
            main_flow();
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL R4 watchdog actual=hung expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule